// File: doc/BRIEF.md
# Time-of-Day Register Freeze and Set Controller

This block keeps hours, minutes, seconds and day-of-week in BCD counters that advance from a 1 Hz tick. The tick comes from a prescaler that counts a 32768 Hz clock enable. A host on a byte-wide strobe bus does not read the counters directly. It reads a set of visible registers that follow the counters on every clock. A control byte holds two freeze bits.

The read-freeze bit holds the visible registers still, so the host can read a consistent time while the counters keep running. Clearing it brings every visible register up to date at once. The set-freeze bit also holds the visible registers, and while it is set the host may overwrite them with a new time. Clearing it copies the visible registers into the counters and restarts the prescaler.

A test bit in the day register replaces the seconds LSB on reads with a square wave taken from the prescaler. With the default width this wave runs at 512 Hz.

Top module: `rtc_freeze_ctrl`

## Requirements
- R1: After reset the counters and visible registers hold 00:00:00 with day-of-week 1, and both freeze bits and the test bit are 0.
- R2: A one-second tick occurs on every 2^PRESC_W-th clock enable. While both freeze bits are 0, each visible register takes the counter value on every clock.
- R3: The counters roll over in BCD with a carry into the next field: seconds 59 to 00, minutes 59 to 00, hours 23 to 00. Day-of-week rolls 7 to 1.
- R4: While control bit 6 (read freeze) is 1, the visible registers do not change. The counters keep counting, so no tick or carry is lost.
- R5: After bit 6 is cleared (with bit 7 at 0), every visible register matches the counters by the next clock.
- R6: While control bit 7 (set freeze) is 1, the visible registers do not track the counters, and host writes to the seconds, minutes, hours and day registers store the written value. While bit 7 is 0, those writes leave the time unchanged. Only the test bit of a day write is taken.
- R7: A control write that clears bit 7 while it is 1 loads every counter from its visible register and restarts the prescaler from 0.
- R8: Bit 6 of the day register is the test bit, writable at any time. While it is 1, a seconds read returns prescaler bit FT_BIT in bit 0. With the default FT_BIT=5 this is 512 Hz. While it is 0, the seconds read returns the time.
- R9: The map is: control at CTRL_ADDR, seconds at +1, minutes at +2, hours at +3, day at +4. A read strobe loads rdata on the next clock edge, and rdata holds between strobes. Control reads as {bit7, bit6, 000000}. Day reads as {0, test, 000, day-of-week}. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32768 Hz clock enable for the prescaler |
| rd_en | input | 1 | Read strobe, one clock |
| wr_en | input | 1 | Write strobe, one clock |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |

## Verification
The hardest case is a carry that ripples through every field while the visible registers are frozen, followed by a release. The visible time must jump forward with nothing lost. The bench reaches this by loading times just below a rollover through the set-freeze path. It then holds the read-freeze bit across several prescaler wraps, with the prescaler shortened to a few hundred enables so that many seconds fit in one run. Random loaded times and random tick counts, checked against a bench model of the counters, cover carries at every field boundary.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int NUM_FIELDS = 4;
   localparam int IDX_SEC    = 0;
   localparam int IDX_MIN    = 1;
   localparam int IDX_HOUR   = 2;
   localparam int IDX_DOW    = 3;

   typedef logic [7:0] bcd_t;

   function automatic bcd_t field_max(input int idx);
      case (idx)
         IDX_SEC, IDX_MIN: return 8'h59;
         IDX_HOUR:         return 8'h23;
         default:          return 8'h07;
      endcase
   endfunction

   function automatic bcd_t field_min(input int idx);
      return (idx == IDX_DOW) ? 8'h01 : 8'h00;
   endfunction

   function automatic bcd_t field_mask(input int idx);
      case (idx)
         IDX_SEC, IDX_MIN: return 8'h7F;
         IDX_HOUR:         return 8'h3F;
         default:          return 8'h07;
      endcase
   endfunction

   function automatic bcd_t bcd_next(input bcd_t v, input bcd_t vmax, input bcd_t vmin);
      if (v == vmax)        return vmin;
      if (v[3:0] >= 4'd9)   return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRESC_W = 15,
   parameter int FT_BIT  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic restart,
   output logic sec_tick,
   output logic ft_wave
);
   logic [PRESC_W-1:0] div_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       div_q <= '0;
      else if (restart) div_q <= '0;
      else if (tick_en) div_q <= div_q + 1'b1;
   end

   assign sec_tick = tick_en && !restart && (&div_q);
   assign ft_wave  = div_q[FT_BIT];
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_pkg::*;
#(
   parameter int IDX = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic load,
   input  bcd_t load_val,
   output bcd_t val,
   output logic carry
);
   localparam bcd_t MAXV = field_max(IDX);
   localparam bcd_t MINV = field_min(IDX);

   always_ff @(posedge clk) begin
      if (!rst_n)    val <= MINV;
      else if (load) val <= load_val;
      else if (inc)  val <= bcd_next(val, MAXV, MINV);
   end

   assign carry = inc && !load && (val == MAXV);
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
   import rtc_pkg::*;
#(
   parameter int                ADDR_W    = 15,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 15'h7FF8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd_en,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [7:0]                  wdata,
   input  logic [NUM_FIELDS-1:0][7:0]  cnt_val,
   input  logic                        ft_wave,
   output logic [NUM_FIELDS-1:0][7:0]  usr_val,
   output logic                        w_frz,
   output logic                        r_frz,
   output logic                        ft_en,
   output logic                        load_cnt,
   output logic [7:0]                  rdata
);
   logic                  ctrl_hit;
   logic [NUM_FIELDS-1:0] hit;
   logic [7:0]            rd_mux;

   assign ctrl_hit = (addr == CTRL_ADDR);

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
      assign hit[i] = (addr == CTRL_ADDR + ADDR_W'(i + 1));
   end

   assign load_cnt = wr_en && ctrl_hit && !wdata[7] && w_frz;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_frz <= 1'b0;
         r_frz <= 1'b0;
         ft_en <= 1'b0;
      end else if (wr_en) begin
         if (ctrl_hit) begin
            w_frz <= wdata[7];
            r_frz <= wdata[6];
         end
         if (hit[IDX_DOW]) ft_en <= wdata[6];
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
         if (!rst_n)
            usr_val[i] <= field_min(i);
         else if (w_frz) begin
            if (wr_en && hit[i]) usr_val[i] <= wdata & field_mask(i);
         end else if (!r_frz)
            usr_val[i] <= cnt_val[i];
      end
   end

   always_comb begin
      rd_mux = 8'h00;
      if (ctrl_hit) rd_mux = {w_frz, r_frz, 6'b0};
      for (int i = 0; i < NUM_FIELDS; i++)
         if (hit[i]) rd_mux = usr_val[i];
      if (hit[IDX_DOW]) rd_mux = {1'b0, ft_en, 3'b000, usr_val[IDX_DOW][2:0]};
      if (hit[IDX_SEC] && ft_en) rd_mux = {usr_val[IDX_SEC][7:1], ft_wave};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= 8'h00;
      else if (rd_en) rdata <= rd_mux;
   end
endmodule

// File: rtl/rtc_freeze_ctrl.sv
module rtc_freeze_ctrl
   import rtc_pkg::*;
#(
   parameter int                ADDR_W    = 15,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 15'h7FF8,
   parameter int                PRESC_W   = 15,
   parameter int                FT_BIT    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   if (FT_BIT >= PRESC_W) begin : g_bad_ft
      $error("FT_BIT must index a prescaler bit");
   end
   if (PRESC_W < 2) begin : g_bad_presc
      $error("PRESC_W must be at least 2");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [NUM_FIELDS-1:0][7:0] cnt_val;
   logic [NUM_FIELDS-1:0][7:0] usr_val;
   logic [NUM_FIELDS:0]        inc_chain;
   logic sec_tick, ft_wave, load_cnt, w_frz, r_frz, ft_en;

   rtc_prescaler #(.PRESC_W(PRESC_W), .FT_BIT(FT_BIT)) u_presc (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(load_cnt),
      .sec_tick(sec_tick), .ft_wave(ft_wave)
   );

   assign inc_chain[0] = sec_tick;

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      rtc_bcd_field #(.IDX(i)) u_fld (
         .clk(clk), .rst_n(rst_n), .inc(inc_chain[i]), .load(load_cnt),
         .load_val(usr_val[i]), .val(cnt_val[i]), .carry(inc_chain[i+1])
      );
   end

   rtc_host_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .cnt_val(cnt_val), .ft_wave(ft_wave), .usr_val(usr_val),
      .w_frz(w_frz), .r_frz(r_frz), .ft_en(ft_en), .load_cnt(load_cnt),
      .rdata(rdata)
   );
endmodule

// File: rtl/rtc_freeze_ctrl_chk.sv
module rtc_freeze_ctrl_chk #(
   parameter int                ADDR_W    = 15,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 15'h7FF8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        rdata,
   input logic              r_frz,
   input logic              w_frz,
   input logic              ft_en,
   input logic              ft_wave,
   input logic              sec_tick,
   input logic              load_cnt,
   input logic              week_wrap,
   input logic [7:0]        usr_sec,
   input logic [7:0]        cnt_sec,
   input logic [7:0]        cnt_dow
);
   localparam logic [ADDR_W-1:0] SEC_A = CTRL_ADDR + ADDR_W'(1);

   a_r2_track: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_frz && !w_frz) |=> usr_sec == $past(cnt_sec));

   a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !load_cnt && cnt_sec == 8'h59) |=> cnt_sec == 8'h00);

   a_r3_week_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      week_wrap |=> cnt_dow == 8'h01);

   a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (r_frz && !w_frz) |=> $stable(usr_sec));

   a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_cnt |=> cnt_sec == $past(usr_sec));

   a_r8_ft_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == SEC_A && ft_en) |=> rdata[0] == $past(ft_wave));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   a_r9_ctrl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == CTRL_ADDR) |=> rdata[5:0] == 6'd0);
endmodule

bind rtc_freeze_ctrl rtc_freeze_ctrl_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
   .r_frz(r_frz), .w_frz(w_frz), .ft_en(ft_en), .ft_wave(ft_wave),
   .sec_tick(sec_tick), .load_cnt(load_cnt), .week_wrap(inc_chain[4]),
   .usr_sec(usr_val[0]), .cnt_sec(cnt_val[0]), .cnt_dow(cnt_val[3])
);

// File: tb/tb_rtc_freeze_ctrl.sv
module tb_rtc_freeze_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 15;
   localparam int PRESC_W    = 8;
   localparam int FT_BIT     = 5;
   localparam logic [14:0] A_CTRL = 15'h7FF8;
   localparam logic [14:0] A_SEC  = 15'h7FF9;
   localparam logic [14:0] A_MIN  = 15'h7FFA;
   localparam logic [14:0] A_HOUR = 15'h7FFB;
   localparam logic [14:0] A_DAY  = 15'h7FFC;

   logic clk = 0, rst_n = 0, tick_en = 0, rd_en = 0, wr_en = 0;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0] wdata = '0, rdata;

   rtc_freeze_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(A_CTRL), .PRESC_W(PRESC_W), .FT_BIT(FT_BIT)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int m_cnt[4], vis[4], m_presc;
   bit m_r, m_w, m_ft;

   function automatic int to_bcd(int v); return (v / 10) * 16 + v % 10; endfunction
   function automatic int from_bcd(int b); return (b / 16) * 10 + b % 16; endfunction

   function automatic void model_tick();
      if (m_presc == (1 << PRESC_W) - 1) begin
         m_cnt[0]++;
         if (m_cnt[0] == 60) begin
            m_cnt[0] = 0; m_cnt[1]++;
            if (m_cnt[1] == 60) begin
               m_cnt[1] = 0; m_cnt[2]++;
               if (m_cnt[2] == 24) begin
                  m_cnt[2] = 0; m_cnt[3]++;
                  if (m_cnt[3] == 8) m_cnt[3] = 1;
               end
            end
         end
      end
      m_presc = (m_presc + 1) % (1 << PRESC_W);
   endfunction

   function automatic void model_sync();
      if (!m_r && !m_w) for (int i = 0; i < 4; i++) vis[i] = m_cnt[i];
   endfunction

   function automatic logic [7:0] expect_rd(logic [14:0] a);
      logic [7:0] v;
      case (a)
         A_CTRL: v = {m_w, m_r, 6'b0};
         A_SEC: begin
            v = 8'(to_bcd(vis[0]));
            if (m_ft) v[0] = 1'((m_presc >> FT_BIT) & 1);
         end
         A_MIN:  v = 8'(to_bcd(vis[1]));
         A_HOUR: v = 8'(to_bcd(vis[2]));
         A_DAY:  v = {1'b0, m_ft, 3'b0, 3'(vis[3])};
         default: v = 8'h00;
      endcase
      return v;
   endfunction

   task automatic check(string req, logic [7:0] got, logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic bus_write(logic [14:0] a, logic [7:0] d);
      bit old_w;
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0;
      @(negedge clk);
      old_w = m_w;
      if (a == A_CTRL) begin
         m_w = d[7]; m_r = d[6];
         if (old_w && !m_w) begin
            for (int i = 0; i < 4; i++) m_cnt[i] = vis[i];
            m_presc = 0;
         end
      end else if (a == A_DAY) begin
         m_ft = d[6];
         if (m_w) vis[3] = d & 8'h07;
      end else if (m_w) begin
         if (a == A_SEC)  vis[0] = from_bcd(d & 8'h7F);
         if (a == A_MIN)  vis[1] = from_bcd(d & 8'h7F);
         if (a == A_HOUR) vis[2] = from_bcd(d & 8'h3F);
      end
      model_sync();
   endtask

   task automatic read_chk(string req, logic [14:0] a);
      @(negedge clk); rd_en = 1; addr = a;
      @(negedge clk); rd_en = 0;
      check(req, rdata, expect_rd(a));
   endtask

   task automatic advance(int n);
      if (n == 0) return;
      @(negedge clk); tick_en = 1;
      repeat (n) @(negedge clk);
      tick_en = 0;
      for (int i = 0; i < n; i++) model_tick();
      model_sync();
   endtask

   task automatic set_time(int h, int m, int s, int dw);
      bus_write(A_CTRL, 8'h80);
      bus_write(A_SEC, 8'(to_bcd(s)));
      bus_write(A_MIN, 8'(to_bcd(m)));
      bus_write(A_HOUR, 8'(to_bcd(h)));
      bus_write(A_DAY, 8'(dw));
      bus_write(A_CTRL, 8'h00);
   endtask

   task automatic read_all(string req);
      read_chk(req, A_SEC); read_chk(req, A_MIN);
      read_chk(req, A_HOUR); read_chk(req, A_DAY);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      m_cnt = '{0, 0, 0, 1}; vis = '{0, 0, 0, 1};
      m_presc = 0; m_r = 0; m_w = 0; m_ft = 0;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state, R9 map and unmapped
      read_chk("R1 ctrl", A_CTRL);
      read_all("R1 time");
      read_chk("R9 unmapped", 15'h7FF7);
      read_chk("R9 unmapped hi", 15'h7FFD);
      // R2 plain counting
      advance(5 * 256 + 40);
      read_all("R2 count");
      // R3 full rollover from 23:59:58 day 7
      set_time(23, 59, 58, 7);
      read_all("R7 load");
      advance(2 * 256);
      read_all("R3 rollover");
      // R4/R5 read freeze across a minute carry
      set_time(10, 14, 58, 3);
      bus_write(A_CTRL, 8'h40);
      read_chk("R9 ctrl", A_CTRL);
      advance(4 * 256 + 17);
      read_all("R4 frozen");
      bus_write(A_CTRL, 8'h00);
      read_all("R5 release");
      // R6 writes ignored while bit7 is 0
      bus_write(A_SEC, 8'h33);
      bus_write(A_HOUR, 8'h11);
      read_all("R6 ignored");
      // R6 set-freeze holds without writes, R7 reload
      bus_write(A_CTRL, 8'h80);
      advance(300);
      read_all("R6 frozen");
      bus_write(A_CTRL, 8'h00);
      advance(256);
      read_all("R7 reload");
      // R8 test bit
      bus_write(A_DAY, 8'h40);
      read_chk("R8 day", A_DAY);
      read_chk("R8 lsb a", A_SEC);
      advance(32);
      read_chk("R8 lsb b", A_SEC);
      advance(19);
      read_chk("R8 lsb c", A_SEC);
      bus_write(A_DAY, 8'h00);
      read_chk("R8 cleared", A_SEC);
      // random loads, runs and freezes
      for (int it = 0; it < 24; it++) begin
         int h, m, s, dw;
         h = $urandom_range(23); m = $urandom_range(59);
         s = $urandom_range(59); dw = $urandom_range(7, 1);
         if (it % 4 == 0) begin m = 59; s = 59 - $urandom_range(2); end
         set_time(h, m, s, dw);
         advance($urandom_range(900));
         if ($urandom_range(1) == 1) begin
            bus_write(A_CTRL, 8'h40);
            advance($urandom_range(700));
            read_chk("R4 rand", A_SEC);
            bus_write(A_CTRL, 8'h00);
         end
         read_all("R3 rand");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule